// File: doc/BRIEF.md
# Three-Wire Serial Byte Memory Command Controller

This block is the device side of a three-wire serial memory link (chip-select, serial clock, data-in, plus a data-out with its own enable). It holds 512 bytes in a register array and carries out the command set a host issues over the link: single and streaming reads, single and page writes, single erase, fill-all, erase-all and the write-protect switch. The three link inputs are brought into a faster system clock through two-stage synchronisers. All decoding happens on detected rising edges of the serial clock.

Programming is deferred. Bytes that arrive during a write frame collect in a page buffer, and the array changes only after chip-select drops. A self-timed countdown of system-clock cycles then stands in for the nonvolatile programming time. While that countdown runs and the host holds chip-select high, data-out reports busy or ready. The ready level stays on data-out until the host clocks in a new start bit.

Top module: `mw_eeprom_top`

## Requirements
- R1: A frame is a 1 start bit, a 2-bit opcode and a 9-bit address, each sampled MSB first on a rising serial-clock edge while chip-select is high. Zeros clocked in before the start bit are ignored.
- R2: Opcode 10 (read) enables data-out after the last address bit. It drives a 0 first, then the addressed byte MSB first, advancing one bit per rising serial-clock edge.
- R3: If chip-select stays high after a read byte, the next byte follows with no gap. The address counts up and wraps from 511 to 0.
- R4: Opcode 01 (write) takes 8-bit bytes after the address. Byte k goes to the address whose upper 5 bits match the start address and whose low 4 bits equal (start low 4 bits + k) mod 16.
- R5: The array is unchanged until chip-select falls after a programming frame. The commit then happens after BUSY_CYCLES system-clock cycles, and serial clocks are ignored until it is done.
- R6: Opcode 11 (erase) sets one byte to FF. Opcode 00 with top address bits 10 sets every byte to FF. Opcode 00 with top address bits 01, followed by one data byte, writes that byte to every location.
- R7: After reset, writes are disabled. Write, erase, erase-all and write-all frames then change nothing and start no busy period. Opcode 00 with top address bits 11 enables writes, and 00 with top address bits 00 disables them. Reads work in either state.
- R8: After a programming frame, raising chip-select shows doOe=1 with doOut=0 while busy and 1 once ready. The ready level survives chip-select toggles until a start bit is clocked in.
- R9: With chip-select low, doOe is 0 and any frame in progress is abandoned. The next frame decodes from its own start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip-select from the host, asynchronous |
| skIn | input | 1 | Serial clock from the host, asynchronous |
| diIn | input | 1 | Serial data from the host, asynchronous |
| doOut | output | 1 | Serial data or ready/busy level to the host |
| doOe | output | 1 | Drive enable for doOut (0 means high impedance) |

## Verification
The hardest state to reach from the ports is the sticky ready level. It needs a programming frame with writes enabled, a chip-select fall, a re-select while the countdown still runs, and then the clearing start bit. The bench uses a short busy count. It re-selects the device within a few cycles of the chip-select fall to see busy, then keeps chip-select high past the countdown. It toggles chip-select to show the ready level persists, and finally clocks a lone start bit. Page wrap and the streaming-read wrap at 511 come from directed frames placed near page and array ends, and random write and read frames check the array against a bench model.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_WIPE   = 2'b10,
    SUB_UNLOCK = 2'b11
  } extSub_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_READ,
    ST_SKIP
  } ctrlState_e;

  typedef enum logic [1:0] {
    PK_NONE,
    PK_PAGE,
    PK_ONE,
    PK_ALL
  } pendKind_e;

  typedef struct packed {
    logic bufByte;
    logic armErase;
    logic armEraseAll;
    logic armWriteAll;
    logic launch;
  } ctrlStb_t;

endpackage

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              pending,
  output logic              commitPulse
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] memArr  [DEPTH];
  logic [DATA_W-1:0] pageBuf [PAGE_N];
  logic [PAGE_N-1:0] pageVld;
  logic [BASE_W-1:0] pageBase;
  logic [ADDR_W-1:0] oneAddr;
  logic [DATA_W-1:0] fillVal;
  logic [BCNT_W-1:0] busyCnt;
  pendKind_e         pendKind;

  assign rdData  = memArr[rdAddr];
  assign pending = (pendKind != PK_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= ERASED;
      for (int i = 0; i < PAGE_N; i++) pageBuf[i] <= '0;
      pageVld     <= '0;
      pageBase    <= '0;
      oneAddr     <= '0;
      fillVal     <= ERASED;
      busyCnt     <= '0;
      busy        <= 1'b0;
      pendKind    <= PK_NONE;
      commitPulse <= 1'b0;
    end else begin
      commitPulse <= 1'b0;
      if (busy) begin
        if (busyCnt == '0) begin
          busy        <= 1'b0;
          commitPulse <= 1'b1;
          pendKind    <= PK_NONE;
          pageVld     <= '0;
          case (pendKind)
            PK_PAGE: begin
              for (int i = 0; i < PAGE_N; i++)
                if (pageVld[i]) memArr[{pageBase, PAGE_W'(i)}] <= pageBuf[i];
            end
            PK_ONE:  memArr[oneAddr] <= fillVal;
            PK_ALL: begin
              for (int i = 0; i < DEPTH; i++) memArr[i] <= fillVal;
            end
            default: ;
          endcase
        end else begin
          busyCnt <= busyCnt - 1'b1;
        end
      end else begin
        if (stb.launch && pendKind != PK_NONE) begin
          busy    <= 1'b1;
          busyCnt <= BCNT_W'(BUSY_CYCLES - 1);
        end
        if (stb.bufByte) begin
          pendKind <= PK_PAGE;
          pageBase <= wrAddr[ADDR_W-1:PAGE_W];
          pageBuf[wrAddr[PAGE_W-1:0]] <= wrData;
          pageVld[wrAddr[PAGE_W-1:0]] <= 1'b1;
        end
        if (stb.armErase) begin
          pendKind <= PK_ONE;
          oneAddr  <= wrAddr;
          fillVal  <= ERASED;
        end
        if (stb.armEraseAll) begin
          pendKind <= PK_ALL;
          fillVal  <= ERASED;
        end
        if (stb.armWriteAll) begin
          pendKind <= PK_ALL;
          fillVal  <= wrData;
        end
      end
    end
  end

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              skIn,
  input  logic              diIn,
  input  logic              busy,
  input  logic              pending,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output ctrlStb_t          stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              doOut,
  output logic              doOe,
  output logic              csSync,
  output logic              writeEn
);

  localparam int MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic [1:0] csPipe, skPipe, diPipe;
  logic       skPrev, csPrev;
  logic       csS, diS, skRise, csFall;

  ctrlState_e        state;
  logic [1:0]        opc;
  logic [ADDR_W-2:0] addrSh;
  logic [DATA_W-2:0] dataSh;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W:0]   outSh;
  logic [CNT_W-1:0]  remBits;
  logic              fillMode;
  logic              statusFlag;

  logic [ADDR_W-1:0] fullAddr;
  logic [1:0]        subCode;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] pageNext;

  assign csS      = csPipe[1];
  assign diS      = diPipe[1];
  assign skRise   = skPipe[1] & ~skPrev;
  assign csFall   = csPrev & ~csS;
  assign csSync   = csS;
  assign fullAddr = {addrSh, diS};
  assign subCode  = fullAddr[ADDR_W-1 -: 2];
  assign seqAddr  = curAddr + 1'b1;
  assign pageNext = {curAddr[ADDR_W-1:PAGE_W], curAddr[PAGE_W-1:0] + 1'b1};
  assign rdAddr   = (state == ST_READ) ? seqAddr : fullAddr;

  assign doOe  = csS & (statusFlag | (state == ST_READ));
  assign doOut = statusFlag ? ~busy : outSh[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe <= '0;
      skPipe <= '0;
      diPipe <= '0;
      skPrev <= 1'b0;
      csPrev <= 1'b0;
    end else begin
      csPipe <= {csPipe[0], csIn};
      skPipe <= {skPipe[0], skIn};
      diPipe <= {diPipe[0], diIn};
      skPrev <= skPipe[1];
      csPrev <= csPipe[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      opc        <= '0;
      addrSh     <= '0;
      dataSh     <= '0;
      cnt        <= '0;
      curAddr    <= '0;
      outSh      <= '0;
      remBits    <= '0;
      fillMode   <= 1'b0;
      statusFlag <= 1'b0;
      writeEn    <= 1'b0;
      stb        <= '0;
      wrAddr     <= '0;
      wrData     <= '0;
    end else begin
      stb <= '0;
      if (!csS) begin
        state <= ST_IDLE;
        if (csFall) begin
          stb.launch <= 1'b1;
          if (pending) statusFlag <= 1'b1;
        end
      end else if (skRise && !busy) begin
        case (state)
          ST_IDLE: begin
            if (diS) begin
              state      <= ST_OPC;
              cnt        <= '0;
              statusFlag <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], diS};
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addrSh <= fullAddr[ADDR_W-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt      <= '0;
              curAddr  <= fullAddr;
              wrAddr   <= fullAddr;
              fillMode <= 1'b0;
              state    <= ST_SKIP;
              case (opcode_e'(opc))
                OP_READ: begin
                  state   <= ST_READ;
                  outSh   <= {1'b0, rdData};
                  remBits <= CNT_W'(DATA_W);
                end
                OP_WRITE: begin
                  if (writeEn) state <= ST_WDATA;
                end
                OP_ERASE: begin
                  if (writeEn) stb.armErase <= 1'b1;
                end
                default: begin
                  case (extSub_e'(subCode))
                    SUB_UNLOCK: writeEn <= 1'b1;
                    SUB_LOCK:   writeEn <= 1'b0;
                    SUB_WIPE:   if (writeEn) stb.armEraseAll <= 1'b1;
                    default: begin
                      fillMode <= 1'b1;
                      if (writeEn) state <= ST_WDATA;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_WDATA: begin
            dataSh <= {dataSh[DATA_W-3:0], diS};
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              cnt    <= '0;
              wrData <= {dataSh, diS};
              if (fillMode) begin
                stb.armWriteAll <= 1'b1;
                state           <= ST_SKIP;
              end else begin
                stb.bufByte <= 1'b1;
                wrAddr      <= curAddr;
                curAddr     <= pageNext;
              end
            end
          end
          ST_READ: begin
            if (remBits != '0) begin
              outSh   <= {outSh[DATA_W-1:0], 1'b0};
              remBits <= remBits - 1'b1;
            end else begin
              curAddr <= seqAddr;
              outSh   <= {rdData, 1'b0};
              remBits <= CNT_W'(DATA_W - 1);
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_top.sv
module mw_eeprom_top
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);

  ctrlStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [DATA_W-1:0] wrData, rdData;
  logic              busy, pending, commitPulse, csSync, writeEn;

  mw_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csIn    (csIn),
    .skIn    (skIn),
    .diIn    (diIn),
    .busy    (busy),
    .pending (pending),
    .rdData  (rdData),
    .rdAddr  (rdAddr),
    .stb     (stb),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .doOut   (doOut),
    .doOe    (doOe),
    .csSync  (csSync),
    .writeEn (writeEn)
  );

  mw_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PAGE_W      (PAGE_W),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .busy        (busy),
    .pending     (pending),
    .commitPulse (commitPulse)
  );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     csSync,
  input logic     busy,
  input logic     commitPulse,
  input logic     writeEn,
  input ctrlStb_t stb,
  input logic     doOe,
  input logic     doOut
);

  logic anyArm;
  assign anyArm = stb.bufByte | stb.armErase | stb.armEraseAll | stb.armWriteAll;

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    doOe |-> csSync) else $error("doOe while deselected"); // R9

  AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (doOe && busy) |-> !doOut) else $error("busy not shown as 0"); // R8

  AST_BUSY_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.launch)) else $error("busy without chip-select fall"); // R5

  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> !busy) else $error("commit left busy high"); // R5

  AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !anyArm) else $error("programming armed during busy"); // R5

  AST_ARM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    anyArm |-> writeEn) else $error("programming armed while disabled"); // R7

endmodule

bind mw_eeprom_top mw_eeprom_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csSync      (csSync),
  .busy        (busy),
  .commitPulse (commitPulse),
  .writeEn     (writeEn),
  .stb         (stb),
  .doOe        (doOe),
  .doOut       (doOut)
);

// File: tb/sim_mw_eeprom_top.sv
module sim_mw_eeprom_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int BUSY       = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0, skIn = 1'b0, diIn = 1'b0;
  logic doOut, doOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit lastDo, lastOe;
  bit [7:0] model [512];
  bit modelWe = 0;
  bit [7:0] wbuf [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_top #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .doOut(doOut), .doOe(doOe)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input bit d);
    diIn = d;
    waitClk(HALF);
    lastDo = doOut;
    lastOe = doOe;
    skIn = 1'b1;
    waitClk(HALF);
    skIn = 1'b0;
  endtask

  task automatic csHigh();
    csIn = 1'b1;
    waitClk(4);
  endtask

  task automatic csLow();
    skIn = 1'b0;
    csIn = 1'b0;
    waitClk(6);
  endtask

  task automatic sendCmd(input bit [1:0] op, input bit [8:0] addr);
    sendBit(1'b1);
    sendBit(op[1]);
    sendBit(op[0]);
    for (int i = 8; i >= 0; i--) sendBit(addr[i]);
  endtask

  function automatic bit [8:0] pageAddr(input bit [8:0] base, input int k);
    bit [3:0] low = base[3:0] + 4'(k);
    return {base[8:4], low};
  endfunction

  // R2 R3: read n bytes and compare with the model
  task automatic readCheck(input bit [8:0] addr, input int n, input string req);
    bit [7:0] got;
    csHigh();
    sendCmd(2'b10, addr);
    sendBit(1'b0);
    chk("R2 dummy zero", lastDo, 0);
    chk("R2 output enabled", lastOe, 1);
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        sendBit(1'b0);
        got[i] = lastDo;
      end
      chk(req, got, model[9'(addr + 9'(b))]);
    end
    csLow();
  endtask

  task automatic extCmd(input bit [1:0] sub);
    csHigh();
    sendCmd(2'b00, {sub, 7'h00});
    csLow();
    if (sub == 2'b11) modelWe = 1;
    if (sub == 2'b00) modelWe = 0;
  endtask

  task automatic sendByte(input bit [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  // R4: page write of n bytes held in wbuf
  task automatic pageWrite(input bit [8:0] addr, input int n);
    csHigh();
    sendCmd(2'b01, addr);
    for (int k = 0; k < n; k++) sendByte(wbuf[k]);
    csLow();
    if (modelWe)
      for (int k = 0; k < n; k++) model[pageAddr(addr, k)] = wbuf[k];
    waitClk(BUSY + 20);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    void'($urandom(32'h1A2B3C));
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);

    // R9 reset state
    chk("R9 reset doOe", doOe, 0);
    csHigh();
    chk("R9 selected idle doOe", doOe, 0);
    csLow();

    // R1 R2 reads of erased array
    readCheck(9'd5, 1, "R2 erased read");

    // R7 write while disabled is ignored
    wbuf[0] = 8'h12;
    pageWrite(9'd5, 1);
    csHigh();
    chk("R7 no status after ignored write", doOe, 0);
    csLow();
    readCheck(9'd5, 1, "R7 ignored write");

    // R1 leading zeros before start bit, enable
    csHigh();
    sendBit(1'b0);
    sendBit(1'b0);
    sendCmd(2'b00, 9'h180);
    csLow();
    modelWe = 1;

    // R8 R5 busy / sticky ready
    csHigh();
    sendCmd(2'b01, 9'd5);
    sendByte(8'hA5);
    csLow();
    model[5] = 8'hA5;
    csIn = 1'b1;
    waitClk(12);
    chk("R8 busy oe", doOe, 1);
    chk("R8 busy level", doOut, 0);
    waitClk(BUSY + 20);
    chk("R8 ready level", doOut, 1);
    csLow();
    csHigh();
    chk("R8 ready sticky oe", doOe, 1);
    chk("R8 ready sticky level", doOut, 1);
    sendBit(1'b1);
    csLow();
    csHigh();
    chk("R8 cleared by start bit", doOe, 0);
    csLow();
    readCheck(9'd5, 1, "R5 committed write");

    // R4 page wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    pageWrite(9'h01E, 4);
    readCheck(9'h010, 16, "R4 page wrap");

    // R3 streaming read across top address
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    pageWrite(9'd510, 2);
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1;
    pageWrite(9'd0, 2);
    readCheck(9'd510, 4, "R3 address wrap");

    // R6 erase one
    csHigh();
    sendCmd(2'b11, 9'd510);
    csLow();
    model[510] = 8'hFF;
    waitClk(BUSY + 20);
    readCheck(9'd509, 3, "R6 erase one");

    // R6 write all
    csHigh();
    sendCmd(2'b00, 9'h080);
    sendByte(8'h3C);
    csLow();
    for (int i = 0; i < 512; i++) model[i] = 8'h3C;
    waitClk(BUSY + 20);
    readCheck(9'd100, 2, "R6 write all");
    readCheck(9'd511, 2, "R6 write all");

    // R6 erase all
    extCmd(2'b10);
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    waitClk(BUSY + 20);
    readCheck(9'd77, 2, "R6 erase all");

    // R9 abort mid-read then fresh frame
    wbuf[0] = 8'h5A;
    pageWrite(9'd40, 1);
    csHigh();
    sendCmd(2'b10, 9'd40);
    sendBit(1'b0);
    sendBit(1'b0);
    csLow();
    chk("R9 deselect drops oe", doOe, 0);
    readCheck(9'd40, 1, "R9 fresh frame");

    // R7 disable, write ignored, read still allowed
    extCmd(2'b00);
    wbuf[0] = 8'h99;
    pageWrite(9'd40, 1);
    readCheck(9'd40, 1, "R7 disabled write");
    csHigh();
    sendCmd(2'b11, 9'd40);
    csLow();
    csHigh();
    chk("R7 erase ignored no status", doOe, 0);
    csLow();
    readCheck(9'd40, 1, "R7 disabled erase");

    // random mix, R4 R3
    extCmd(2'b11);
    for (int it = 0; it < 24; it++) begin
      bit [8:0] a = 9'($urandom_range(0, 511));
      if ($urandom_range(0, 1) == 0) begin
        int n = $urandom_range(1, 18);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        pageWrite(a, n);
      end else begin
        readCheck(a, $urandom_range(1, 3), "R3 random read");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule